// File: doc/BRIEF.md
# Saturating Up/Down Wiper Counter

This block is the digital control core of a 64-step digitally adjustable resistor. It keeps a 6-bit wiper code that starts at midscale (code 32) after reset. Each falling edge of an external step clock moves the code by one position, but only while the active-low select is held low. The up/down input chooses the direction of the step. The code stops at 0 and at 63 and never wraps. A second output carries the code of the complementary resistor section, which is always 64 minus the wiper code.

All three control pins are asynchronous to the fast system clock. Each one passes through a two-flop synchroniser. A two-state phase machine then watches the synchronised step clock. `PH_WAIT_HIGH` waits for the clock to be high. When it sees the clock high it moves to `PH_WAIT_FALL`. `PH_WAIT_FALL` moves back to `PH_WAIT_HIGH` once it sees the clock low. That transition is the detected falling edge, and in that same cycle the machine issues a step action:

- `ACT_INC` when select is low and the direction input is high.
- `ACT_DEC` when select is low and the direction input is low.
- `ACT_NONE` in every other case.

The position register applies the action with clamping. It raises a one-cycle done pulse only when the code actually moves. A pin change reaches the wiper output on the third rising system-clock edge after the change.

Top module: `wiper_step_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `wiper_code` is 32, `comp_code` is 32 and `step_done` is 0.
- R2: A falling edge on `step_clk` with `sel_n` low and `dir_up` = 1 raises `wiper_code` by one. The new value appears on the third rising system-clock edge after the pin edge.
- R3: A falling edge on `step_clk` with `sel_n` low and `dir_up` = 0 lowers `wiper_code` by one.
- R4: While `sel_n` is high, edges on `step_clk` leave `wiper_code` unchanged.
- R5: At code 63 a further up step leaves the code at 63. It does not wrap to 0.
- R6: At code 0 a further down step leaves the code at 0. It does not wrap to 63.
- R7: `comp_code` (7 bits) always equals 64 minus `wiper_code`.
- R8: `step_done` is high for exactly the one cycle in which `wiper_code` shows a new value. It stays low for clamped steps.
- R9: A rising edge on `step_clk` causes no step.
- R10: `dir_up` is sampled together with the step-clock falling edge. A direction change made at the same instant as the edge applies to that step.
- R11: Successive falling edges with an unchanged direction keep stepping the same way, one position per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; presets the wiper to midscale |
| sel_n | input | 1 | Asynchronous active-low select |
| step_clk | input | 1 | Asynchronous step clock; steps on its falling edge |
| dir_up | input | 1 | Asynchronous direction: 1 up, 0 down |
| wiper_code | output | 6 | Wiper position code |
| comp_code | output | 7 | Complementary code, 64 minus the wiper code |
| step_done | output | 1 | One-cycle pulse when the code changes |

## Verification
Two functions can fall in the same cycle: a detected falling edge and a change of direction or select. The bench provokes this by switching `dir_up` at the same instant as `step_clk` falls, so both travel the synchronisers together. It judges the result by whether the step follows the new direction. The bench also drives steps into both end stops, where a detected edge meets a clamp. There the code and `step_done` must both hold, while a behavioural model is compared on every clock.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;
    typedef enum logic {
        PH_WAIT_HIGH = 1'b0,
        PH_WAIT_FALL = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2
    } step_act_t;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= RST_VAL;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/wiper_phase_fsm.sv
module wiper_phase_fsm
    import wiper_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clk_s,
    input  logic      csn_s,
    input  logic      up_s,
    output step_act_t act
);
    phase_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_WAIT_HIGH: if (clk_s)  state_d = PH_WAIT_FALL;
            PH_WAIT_FALL: if (!clk_s) state_d = PH_WAIT_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_WAIT_HIGH;
        else     state_q <= state_d;
    end

    always_comb begin
        act = ACT_NONE;
        unique case (state_q)
            PH_WAIT_HIGH: act = ACT_NONE;
            PH_WAIT_FALL: begin
                if (!clk_s && !csn_s) act = up_s ? ACT_INC : ACT_DEC;
            end
        endcase
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wiper_step_pkg::*;
#(
    parameter int POS_W  = 6,
    localparam int COMP_W = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  step_act_t         act,
    output logic [POS_W-1:0]  pos,
    output logic [COMP_W-1:0] comp,
    output logic              done
);
    localparam logic [POS_W-1:0]  POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0]  POS_MID = POS_W'(1 << (POS_W - 1));
    localparam logic [COMP_W-1:0] FULL    = COMP_W'(1 << POS_W);

    logic [POS_W-1:0] pos_d;
    logic             moved;

    always_comb begin
        pos_d = pos;
        moved = 1'b0;
        unique case (act)
            ACT_INC: if (pos != POS_MAX) begin pos_d = pos + 1'b1; moved = 1'b1; end
            ACT_DEC: if (pos != '0)      begin pos_d = pos - 1'b1; moved = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= POS_MID;
            comp <= FULL - {1'b0, POS_MID};
            done <= 1'b0;
        end else begin
            pos  <= pos_d;
            comp <= FULL - {1'b0, pos_d};
            done <= moved;
        end
    end
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wiper_step_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int SYNC_LEN = 2,
    localparam int COMP_W  = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              step_clk,
    input  logic              dir_up,
    output logic [POS_W-1:0]  wiper_code,
    output logic [COMP_W-1:0] comp_code,
    output logic              step_done
);
    logic [2:0] pins_s;
    logic       csn_s, clk_s, up_s;
    step_act_t  act;

    wiper_sync #(.WIDTH(3), .STAGES(SYNC_LEN), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({sel_n, step_clk, dir_up}),
        .sync_out (pins_s)
    );

    assign csn_s = pins_s[2];
    assign clk_s = pins_s[1];
    assign up_s  = pins_s[0];

    wiper_phase_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .clk_s (clk_s),
        .csn_s (csn_s),
        .up_s  (up_s),
        .act   (act)
    );

    wiper_pos_reg #(.POS_W(POS_W)) u_pos (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .pos  (wiper_code),
        .comp (comp_code),
        .done (step_done)
    );
endmodule

// File: rtl/wiper_step_ctrl_chk.sv
module wiper_step_ctrl_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [POS_W-1:0] wiper,
    input logic [POS_W:0]   comp,
    input logic             done,
    input logic             csn_s
);
    localparam logic [POS_W-1:0] TOP  = {POS_W{1'b1}};
    localparam logic [POS_W:0]   FULL = (POS_W+1)'(1 << POS_W);

    // R2
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper) |-> (wiper == $past(wiper) + 1'b1) || (wiper == $past(wiper) - 1'b1));
    // R8
    done_on_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper) |-> done);
    // R8
    done_only_move_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !$stable(wiper));
    // R7
    comp_sum_chk: assert property (@(posedge clk) disable iff (rst)
        comp == FULL - {1'b0, wiper});
    // R4
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> $stable(wiper));
    // R5
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (wiper == TOP) |=> (wiper != '0));
    // R6
    no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (wiper == '0) |=> (wiper != TOP));
endmodule

bind wiper_step_ctrl wiper_step_ctrl_chk #(.POS_W(POS_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wiper (wiper_code),
    .comp  (comp_code),
    .done  (step_done),
    .csn_s (csn_s)
);

// File: tb/wiper_step_ctrl_tb_top.sv
module wiper_step_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       step_clk = 1'b0;
    logic       dir_up = 1'b0;
    logic [5:0] wiper_code;
    logic [6:0] comp_code;
    logic       step_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wiper_step_ctrl dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .step_clk(step_clk),
        .dir_up(dir_up), .wiper_code(wiper_code), .comp_code(comp_code),
        .step_done(step_done)
    );

    // Behavioural reference: pin histories as queues, position as integer
    int m_pos = 32;
    int m_done = 0;
    int m_prev_clk = 0;
    int q_cs[$];
    int q_ck[$];
    int q_ud[$];

    initial begin
        q_cs = {1, 1};
        q_ck = {0, 0};
        q_ud = {0, 0};
    end

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 32; m_done = 0; m_prev_clk = 0;
            q_cs = {1, 1}; q_ck = {0, 0}; q_ud = {0, 0};
        end else begin
            int cs_now, ck_now, ud_now;
            cs_now = q_cs[0]; ck_now = q_ck[0]; ud_now = q_ud[0];
            m_done = 0;
            if (m_prev_clk == 1 && ck_now == 0 && cs_now == 0) begin
                if (ud_now == 1 && m_pos < 63) begin m_pos++; m_done = 1; end
                else if (ud_now == 0 && m_pos > 0) begin m_pos--; m_done = 1; end
            end
            m_prev_clk = ck_now;
            void'(q_cs.pop_front()); q_cs.push_back(int'(sel_n));
            void'(q_ck.pop_front()); q_ck.push_back(int'(step_clk));
            void'(q_ud.pop_front()); q_ud.push_back(int'(dir_up));
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 wiper vs model", int'(wiper_code), m_pos);
            check("R7 comp vs model", int'(comp_code), 64 - m_pos);
            check("R8 done vs model", int'(step_done), m_done);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) step_clk = 1'b1;
            repeat (4) @(negedge clk);
            step_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 wiper in reset", int'(wiper_code), 32);
        check("R1 comp in reset", int'(comp_code), 32);
        check("R1 done in reset", int'(step_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wiper after reset", int'(wiper_code), 32);

        sel_n = 1'b0; dir_up = 1'b1;
        pulse(3);
        check("R11 three up steps", int'(wiper_code), 35);
        check("R7 comp after up", int'(comp_code), 29);

        dir_up = 1'b0;
        pulse(2);
        check("R3 two down steps", int'(wiper_code), 33);

        sel_n = 1'b1; dir_up = 1'b1;
        pulse(4);
        check("R4 deselected edges", int'(wiper_code), 33);
        sel_n = 1'b0;

        // R9: rising edge only
        @(negedge clk) step_clk = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 rising edge no step", int'(wiper_code), 33);
        step_clk = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 latency two cycles not yet", int'(wiper_code), 33);
        @(negedge clk);
        check("R2 step on third edge", int'(wiper_code), 34);
        check("R8 done with step", int'(step_done), 1);
        @(negedge clk);
        check("R8 done one cycle", int'(step_done), 0);

        pulse(40);
        check("R5 clamp at top", int'(wiper_code), 63);
        check("R7 comp at top", int'(comp_code), 1);

        dir_up = 1'b0;
        pulse(70);
        check("R6 clamp at bottom", int'(wiper_code), 0);
        check("R7 comp at bottom", int'(comp_code), 64);

        // R10: direction flips at the same instant as the falling edge
        @(negedge clk) step_clk = 1'b1;
        repeat (4) @(negedge clk);
        step_clk = 1'b0; dir_up = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 same-edge direction", int'(wiper_code), 1);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule